// File: doc/BRIEF.md
# In-Order Completion Queue

A five-slot ring that tracks instructions from dispatch to retirement. Each cycle the dispatch stage asks for up to two slots. If the queue has room it records the instructions' tags in program order and hands back the slot numbers it used. Execution units later report completion by slot number through two finish ports, and these reports may arrive in any order. The queue retires instructions only from its oldest end, up to two per cycle, and only while each one in turn has been reported finished. This restores program order at commit.

The queue holds only a valid bit, a done bit and a tag per slot. It stores no result data and no rename state. A flush empties the whole queue in one cycle and returns both ring pointers to slot 0.

Top module: `cmpl_queue`

## Requirements
- R1: After reset the queue is empty. `disp_ready_o` is 1 for a request of two, `disp_idx_o` offers slots 0 (lane 0) and 1 (lane 1), and `cmt_valid_o` is 0.
- R2: A dispatch of N (1 or 2) instructions takes place at the clock edge when `disp_ready_o` is 1. Lane L, in bits [L*3 +: 3], receives the slot (tail+L) mod 5, and that slot stores tag bits [L*6 +: 6].
- R3: `disp_ready_o` is 1 only when the requested count is at most 2 and at most the number of free slots. A request of 3 is never granted. While ready is 0 nothing is allocated.
- R4: A slot that has been reported finished does not commit until every older slot has committed.
- R5: Each cycle the queue commits the longest run of finished slots starting at the head, up to two. Lane 0 is the head. `cmt_idx_o` and `cmt_tag_o` give the slot and its stored tag. Lane 1 is valid only when lane 0 is valid.
- R6: A finish report takes effect at the clock edge. The slot it names can commit no earlier than the following cycle. A report that names an empty slot or an index of 5 or more is ignored.
- R7: The head and tail wrap from slot 4 to slot 0, for both allocation and commit.
- R8: While `flush_i` is 1, `cmt_valid_o` is 0. After that edge the queue is empty, and the next dispatch receives slots 0 and 1.
- R9: Free space is counted before the current cycle's commits. With five slots in use, a request is refused even in a cycle that commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and reset the pointers |
| disp_num_i | input | 2 | Number of slots requested this cycle |
| disp_tag_i | input | 12 | Tag per dispatch lane, 6 bits each |
| disp_ready_o | output | 1 | Request can be granted this cycle |
| disp_idx_o | output | 6 | Slot offered to each dispatch lane |
| fin_valid_i | input | 2 | Finish report valid per port |
| fin_idx_i | input | 6 | Finished slot per port, 3 bits each |
| cmt_valid_o | output | 2 | Commit lane valid |
| cmt_idx_o | output | 6 | Committed slot per lane |
| cmt_tag_o | output | 12 | Committed tag per lane |

## Verification
The hardest states to reach are those where the ring is full and wrapped at the same moment. In these states a younger slot has finished while an older one is still pending, and a commit competes with a new request that the free-space rule must still refuse. A directed sequence first fills all five slots. It then finishes them out of order and re-dispatches across the wrap, so that both commit lanes read slots 4 and 0. A few thousand cycles of pseudo-random requests, finish indices (including indices that name no slot) and rare flushes then run against a bench-side slot model, which predicts every output in every cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
  // a < n and b <= n assumed
  function automatic int unsigned ring_add(input int unsigned a, input int unsigned b,
                                           input int unsigned n);
    int unsigned s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/cq_alloc.sv
module cq_alloc
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned LANES = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned NUM_W = $clog2(LANES + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            flush_i,
  input  logic [NUM_W-1:0]                disp_num_i,
  input  logic [CNT_W-1:0]                count_i,
  output logic                            ready_o,
  output logic                            fire_o,
  output logic [LANES-1:0][IDX_W-1:0]     idx_o
);
  logic [IDX_W-1:0] tail_q;
  logic [CNT_W-1:0] free_cnt;

  assign free_cnt = CNT_W'(DEPTH) - count_i;
  assign ready_o  = (32'(disp_num_i) <= LANES) && (CNT_W'(disp_num_i) <= free_cnt);
  assign fire_o   = ready_o && (disp_num_i != '0) && !flush_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign idx_o[l] = IDX_W'(ring_add(32'(tail_q), l, DEPTH));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tail_q <= '0;
    else if (flush_i) tail_q <= '0;
    else if (fire_o)  tail_q <= IDX_W'(ring_add(32'(tail_q), 32'(disp_num_i), DEPTH));
  end

  a_r3_stall_holds_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_num_i != '0 && !ready_o && !flush_i) |=> $stable(tail_q));
endmodule

// File: rtl/cq_retire.sv
module cq_retire
  import cq_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned LANES = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned NUM_W = $clog2(LANES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic [CNT_W-1:0]            count_i,
  input  logic [DEPTH-1:0]            ready_i,
  output logic [LANES-1:0]            cmt_o,
  output logic [LANES-1:0][IDX_W-1:0] idx_o,
  output logic [NUM_W-1:0]            num_o
);
  logic [IDX_W-1:0] head_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign idx_o[l] = IDX_W'(ring_add(32'(head_q), l, DEPTH));
  end

  // in-order run of finished slots from the head
  always_comb begin
    logic run;
    run   = !flush_i;
    num_o = '0;
    for (int l = 0; l < LANES; l++) begin
      run      = run && (32'(count_i) > l) && ready_i[idx_o[l]];
      cmt_o[l] = run;
      if (run) num_o = num_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      head_q <= '0;
    else if (flush_i) head_q <= '0;
    else              head_q <= IDX_W'(ring_add(32'(head_q), 32'(num_o), DEPTH));
  end

  a_r5_no_commit_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> (cmt_o == '0));
endmodule

// File: rtl/cq_occ.sv
module cq_occ #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned LANES = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned NUM_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             fire_i,
  input  logic [NUM_W-1:0] add_i,
  input  logic [NUM_W-1:0] sub_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (flush_i) count_o <= '0;
    else              count_o <= count_o + (fire_i ? CNT_W'(add_i) : '0) - CNT_W'(sub_i);
  end

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
endmodule

// File: rtl/cmpl_queue.sv
module cmpl_queue #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned LANES = 2,
  parameter int unsigned FIN_N = 2,
  parameter int unsigned TAG_W = 6,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned NUM_W = $clog2(LANES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_i,
  input  logic [NUM_W-1:0]       disp_num_i,
  input  logic [LANES*TAG_W-1:0] disp_tag_i,
  output logic                   disp_ready_o,
  output logic [LANES*IDX_W-1:0] disp_idx_o,
  input  logic [FIN_N-1:0]       fin_valid_i,
  input  logic [FIN_N*IDX_W-1:0] fin_idx_i,
  output logic [LANES-1:0]       cmt_valid_o,
  output logic [LANES*IDX_W-1:0] cmt_idx_o,
  output logic [LANES*TAG_W-1:0] cmt_tag_o
);
  logic [CNT_W-1:0]             count_q;
  logic                         alloc_fire;
  logic [LANES-1:0][IDX_W-1:0]  alloc_idx, ret_idx;
  logic [NUM_W-1:0]             ret_num;
  logic [DEPTH-1:0]             vld_q, done_q, alloc_hit, ret_hit, fin_hit;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q, alloc_tag;

  cq_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
    .clk_i, .rst_ni, .flush_i, .disp_num_i, .count_i(count_q),
    .ready_o(disp_ready_o), .fire_o(alloc_fire), .idx_o(alloc_idx));

  cq_retire #(.DEPTH(DEPTH), .LANES(LANES)) u_retire (
    .clk_i, .rst_ni, .flush_i, .count_i(count_q), .ready_i(vld_q & done_q),
    .cmt_o(cmt_valid_o), .idx_o(ret_idx), .num_o(ret_num));

  cq_occ #(.DEPTH(DEPTH), .LANES(LANES)) u_occ (
    .clk_i, .rst_ni, .flush_i, .fire_i(alloc_fire), .add_i(disp_num_i),
    .sub_i(ret_num), .count_o(count_q));

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign disp_idx_o[l*IDX_W +: IDX_W] = alloc_idx[l];
    assign cmt_idx_o[l*IDX_W +: IDX_W]  = ret_idx[l];
    assign cmt_tag_o[l*TAG_W +: TAG_W]  = tag_q[ret_idx[l]];
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_comb begin
      alloc_hit[e] = 1'b0;
      alloc_tag[e] = '0;
      ret_hit[e]   = 1'b0;
      fin_hit[e]   = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        if (alloc_fire && NUM_W'(l) < disp_num_i && alloc_idx[l] == IDX_W'(e)) begin
          alloc_hit[e] = 1'b1;
          alloc_tag[e] = disp_tag_i[l*TAG_W +: TAG_W];
        end
        if (cmt_valid_o[l] && ret_idx[l] == IDX_W'(e)) ret_hit[e] = 1'b1;
      end
      for (int k = 0; k < FIN_N; k++)
        if (fin_valid_i[k] && fin_idx_i[k*IDX_W +: IDX_W] == IDX_W'(e)) fin_hit[e] = 1'b1;
    end

    // priority: flush, allocate, retire, finish
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        done_q[e] <= 1'b0;
        tag_q[e]  <= '0;
      end else if (flush_i) begin
        vld_q[e]  <= 1'b0;
        done_q[e] <= 1'b0;
      end else if (alloc_hit[e]) begin
        vld_q[e]  <= 1'b1;
        done_q[e] <= 1'b0;
        tag_q[e]  <= alloc_tag[e];
      end else if (ret_hit[e]) begin
        vld_q[e]  <= 1'b0;
        done_q[e] <= 1'b0;
      end else if (fin_hit[e] && vld_q[e]) begin
        done_q[e] <= 1'b1;
      end
    end

    a_r2_alloc_into_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_hit[e] |-> !vld_q[e]);
    a_r6_done_from_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_q[e]) |-> $past(fin_hit[e] && vld_q[e]));
    a_r6_no_same_cycle_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fin_hit[e] && !done_q[e]) |-> !ret_hit[e]);
  end

  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0 && count_q == '0));
  a_r9_count_matches_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_q) == $countones(vld_q));
endmodule

// File: tb/sim_cmpl_queue.sv
`timescale 1ns/1ps
module sim_cmpl_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush;
  logic [1:0]  disp_num;
  logic [11:0] disp_tag;
  logic        disp_ready;
  logic [5:0]  disp_idx;
  logic [1:0]  fin_valid;
  logic [5:0]  fin_idx;
  logic [1:0]  cmt_valid;
  logic [5:0]  cmt_idx;
  logic [11:0] cmt_tag;

  int checks = 0;
  int errors = 0;

  int m_head, m_tail, m_cnt;
  logic m_vld [5];
  logic m_done [5];
  logic [5:0] m_tag [5];
  logic e_ready, e_c0, e_c1;

  always #2.5 clk = ~clk;

  cmpl_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .disp_num_i(disp_num),
    .disp_tag_i(disp_tag), .disp_ready_o(disp_ready), .disp_idx_o(disp_idx),
    .fin_valid_i(fin_valid), .fin_idx_i(fin_idx), .cmt_valid_o(cmt_valid),
    .cmt_idx_o(cmt_idx), .cmt_tag_o(cmt_tag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive at negedge, compare outputs with the slot model
  task automatic step(input int num, input logic [11:0] tags, input logic [1:0] fv,
                      input int f0, input int f1, input logic fl);
    @(negedge clk);
    disp_num  = 2'(num);
    disp_tag  = tags;
    fin_valid = fv;
    fin_idx   = {3'(f1), 3'(f0)};
    flush     = fl;
    #1;
    e_ready = (num <= 2) && (m_cnt + num <= 5);
    e_c0 = !fl && m_cnt > 0 && m_done[m_head];
    e_c1 = e_c0 && m_cnt > 1 && m_done[(m_head + 1) % 5];
    chk("R3 ready", int'(disp_ready), int'(e_ready));
    chk("R2 lane0 slot", int'(disp_idx[2:0]), m_tail);
    chk("R2 lane1 slot", int'(disp_idx[5:3]), (m_tail + 1) % 5);
    chk("R5 commit valid", int'(cmt_valid), int'({e_c1, e_c0}));
    if (e_c0) begin
      chk("R5 lane0 slot", int'(cmt_idx[2:0]), m_head);
      chk("R5 lane0 tag", int'(cmt_tag[5:0]), int'(m_tag[m_head]));
    end
    if (e_c1) begin
      chk("R5 lane1 slot", int'(cmt_idx[5:3]), (m_head + 1) % 5);
      chk("R5 lane1 tag", int'(cmt_tag[11:6]), int'(m_tag[(m_head + 1) % 5]));
    end
  endtask

  task automatic tick();
    int nc;
    @(posedge clk);
    nc = int'(e_c0) + int'(e_c1);
    if (flush) begin
      for (int i = 0; i < 5; i++) begin m_vld[i] = 0; m_done[i] = 0; end
      m_head = 0; m_tail = 0; m_cnt = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        int fi;
        fi = int'(fin_idx[k*3 +: 3]);
        if (fin_valid[k] && fi < 5 && m_vld[fi]) m_done[fi] = 1;
      end
      for (int c = 0; c < nc; c++) begin
        m_vld[(m_head + c) % 5] = 0;
        m_done[(m_head + c) % 5] = 0;
      end
      m_head = (m_head + nc) % 5;
      if (e_ready && disp_num != 0) begin
        for (int l = 0; l < int'(disp_num); l++) begin
          m_vld[(m_tail + l) % 5] = 1;
          m_done[(m_tail + l) % 5] = 0;
          m_tag[(m_tail + l) % 5] = disp_tag[l*6 +: 6];
        end
        m_tail = (m_tail + int'(disp_num)) % 5;
        m_cnt = m_cnt + int'(disp_num);
      end
      m_cnt = m_cnt - nc;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_head = 0; m_tail = 0; m_cnt = 0;
    for (int i = 0; i < 5; i++) begin m_vld[i] = 0; m_done[i] = 0; m_tag[i] = '0; end
    flush = 0; disp_num = 0; disp_tag = 0; fin_valid = 0; fin_idx = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step(2, {6'd2, 6'd1}, 2'b00, 0, 0, 0);
    chk("R1 ready", int'(disp_ready), 1);
    chk("R1 slots", int'(disp_idx), 8);
    chk("R1 no commit", int'(cmt_valid), 0);
    tick();
    step(2, {6'd4, 6'd3}, 2'b00, 0, 0, 0); tick();
    step(1, {6'd0, 6'd5}, 2'b00, 0, 0, 0); tick();
    // R9 full
    step(1, {6'd0, 6'd6}, 2'b00, 0, 0, 0);
    chk("R9 full refuses", int'(disp_ready), 0);
    tick();
    // R4 younger slots finish first
    step(0, 12'd0, 2'b11, 3, 2, 0);
    chk("R6 no commit on report cycle", int'(cmt_valid), 0);
    tick();
    step(0, 12'd0, 2'b00, 0, 0, 0);
    chk("R4 younger done waits", int'(cmt_valid), 0);
    tick();
    step(1, {6'd0, 6'd6}, 2'b01, 0, 0, 0);
    chk("R6 head report same cycle", int'(cmt_valid), 0);
    tick();
    step(1, {6'd0, 6'd6}, 2'b00, 0, 0, 0);
    chk("R4 head commits alone", int'(cmt_valid), 1);
    chk("R4 head tag", int'(cmt_tag[5:0]), 1);
    chk("R9 commit not counted", int'(disp_ready), 0);
    tick();
    step(1, {6'd0, 6'd6}, 2'b01, 1, 0, 0);
    chk("R7 tail wraps", int'(disp_idx[2:0]), 0);
    tick();
    step(0, 12'd0, 2'b00, 0, 0, 0);
    chk("R5 dual commit", int'(cmt_valid), 3);
    chk("R5 dual tags", int'(cmt_tag), 12'h0C2);
    tick();
    step(0, 12'd0, 2'b00, 0, 0, 0);
    chk("R5 run stops", int'(cmt_valid), 1);
    tick();
    step(2, {6'd8, 6'd7}, 2'b00, 0, 0, 0);
    chk("R2 slots after wrap", int'(disp_idx), {3'd2, 3'd1});
    tick();
    step(0, 12'd0, 2'b11, 4, 0, 0); tick();
    step(0, 12'd0, 2'b00, 0, 0, 0);
    chk("R7 commit wraps", int'(cmt_idx), {3'd0, 3'd4});
    chk("R7 commit valid", int'(cmt_valid), 3);
    tick();
    step(0, 12'd0, 2'b01, 1, 0, 1);
    chk("R8 commit masked", int'(cmt_valid), 0);
    tick();
    step(2, {6'd10, 6'd9}, 2'b00, 0, 0, 0);
    chk("R8 pointers reset", int'(disp_idx), 8);
    chk("R8 room after flush", int'(disp_ready), 1);
    tick();

    // sweep against the model
    for (int n = 0; n < 4000; n++) begin
      int fi0, fi1;
      fi0 = (n % 3 == 0) ? int'($urandom % 8) : (m_head + int'($urandom % 3)) % 5;
      fi1 = int'($urandom % 8);
      step(int'($urandom % 4), 12'($urandom), 2'($urandom), fi0, fi1,
           ($urandom % 80) == 0);
      tick();
    end
    summary();
  end
endmodule